// File: doc/BRIEF.md
# Streaming Ones' Complement Checksum Unit

This block sums a stream of fixed-width words with ones' complement arithmetic: whenever an addition carries out of the top bit, that carry goes back in at the least significant bit. Each addition finishes in the same cycle it starts, so the running sum never grows wider than one word. When the word marked as the last of a packet is accepted, the block captures three results. The checksum output is the bitwise inverse of the final sum. The ok flag is high when the final sum is all ones. The done output pulses for one cycle.

One unit serves both directions. A transmitter feeds only the payload words and takes the checksum output as the word to append. A receiver feeds the payload together with the received checksum word and reads the ok flag. A clear input drops a partly summed packet. After each last word the accumulator returns to zero by itself, so packets can follow each other with no idle cycle between them.

Top module: `ones_csum_unit`

## Requirements
- R1: Every accepted word is added to the running sum modulo 2^W−1: the carry out of bit W−1 is added back at bit 0 in the same cycle. Example: with W=16, the words 0xF000 four times give 0xC003.
- R2: The checksum output equals the bitwise inverse of the final sum. It is updated on the clock edge that accepts the last word. With W=8, the words 0xFE and 0x05 give the sum 0x04 and the checksum 0xFB.
- R3: The ok output is 1 exactly when the final sum is all ones. With W=8, the words 0xFE, 0x05 and 0xFB give ok=1. Changing one bit of the checksum word gives ok=0.
- R4: The done output is high for one cycle, in the cycle after each accepted word that has the last flag set. Otherwise it is low. Two lasts on consecutive cycles give two consecutive done pulses.
- R5: When clear is high, the accumulator is set to zero. If a valid word arrives in the same cycle, that word becomes the first word of a new sum.
- R6: While valid is low, the data word and the last flag have no effect on the sum or on the outputs.
- R7: After a last word, the next accepted word starts a new sum from zero, with no need to pulse clear.
- R8: Synchronous active-high reset clears done, ok, the checksum output (all zeros) and the accumulator. This includes a reset in the middle of a packet.
- R9: The checksum and ok outputs keep their values between done pulses.
- R10: Both encodings of zero are kept apart. An all-ones word summed alone gives all ones (ok=1, checksum 0). A sum is all zeros only when every word was zero. For example, 0xFFFF plus 0x0001 gives 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Clear the running sum to zero |
| in_valid_i | input | 1 | Data word is valid this cycle |
| in_word_i | input | W | Data word |
| in_last_i | input | 1 | Marks the final word of a packet (only meaningful with valid) |
| csum_o | output | W | Inverse of the final sum of the last finished packet |
| done_o | output | 1 | One-cycle pulse after the last word is accepted |
| ok_o | output | 1 | Final sum of the last finished packet was all ones |

## Verification
All three results are registered on the rising edge that accepts the last word, so they can first be seen one cycle after that word is presented. The bench drives inputs on falling edges and reads done, the checksum and ok at the next falling edge, which falls in the middle of that result cycle. It then reads them again one cycle later to confirm that done has dropped and the other two outputs have held. Clear, reset and ignored invalid words are checked through the checksum of a packet completed right after them.

// File: rtl/ocs_pkg.sv
package ocs_pkg;

  // Selects the value the next addition builds on.
  typedef enum logic [1:0] {
    BASE_RUN   = 2'd0,  // continue the running sum
    BASE_FRESH = 2'd1,  // start from zero (clear or restart)
    BASE_HOLD  = 2'd2   // no word accepted this cycle
  } base_sel_e;

  // Register update decided by the accumulator control.
  typedef enum logic [1:0] {
    ACC_KEEP  = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_ZERO  = 2'd2
  } acc_op_e;

endpackage

// File: rtl/ocs_fold_adder.sv
module ocs_fold_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int WIDE = W + 1;

  logic [WIDE-1:0] raw;
  logic            wrap;

  // Plain binary add, then fold the carry back at bit 0. The fold can
  // never carry again: when wrap is set the low part is at most 2^W-2.
  always_comb begin
    raw   = {1'b0, a_i} + {1'b0, b_i};
    wrap  = raw[W];
    sum_o = raw[W-1:0] + {{(W-1){1'b0}}, wrap};
  end

  // Positive zero only comes out of two positive-zero operands.
  always_comb begin
    AST_ZERO_ONLY_FROM_ZEROS: assert ((sum_o == '0) == ((a_i == '0) && (b_i == '0)) || $isunknown({a_i, b_i})); // R10
  end

endmodule

// File: rtl/ocs_accum.sv
module ocs_accum
  import ocs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         valid_i,
  input  logic [W-1:0] word_i,
  input  logic         last_i,
  output logic [W-1:0] final_o,
  output logic         close_o
);
  logic [W-1:0] acc_q;
  logic [W-1:0] base;
  logic [W-1:0] added;
  base_sel_e    sel;
  acc_op_e      op;

  always_comb begin
    if (!valid_i)   sel = BASE_HOLD;
    else if (clr_i) sel = BASE_FRESH;
    else            sel = BASE_RUN;
  end

  always_comb begin
    unique case (sel)
      BASE_FRESH: base = '0;
      BASE_RUN:   base = acc_q;
      default:    base = acc_q;
    endcase
  end

  ocs_fold_adder #(.W(W)) u_add (
    .a_i   (base),
    .b_i   (word_i),
    .sum_o (added)
  );

  always_comb begin
    if (sel == BASE_HOLD) op = clr_i ? ACC_ZERO : ACC_KEEP;
    else if (last_i)      op = ACC_ZERO;
    else                  op = ACC_LOAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else begin
      unique case (op)
        ACC_LOAD: acc_q <= added;
        ACC_ZERO: acc_q <= '0;
        default:  acc_q <= acc_q;
      endcase
    end
  end

  assign final_o = added;
  assign close_o = valid_i && last_i;

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !valid_i) |=> (acc_q == '0)); // R5
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !clr_i) |=> $stable(acc_q)); // R6
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid_i && last_i) |=> (acc_q == '0)); // R7

endmodule

// File: rtl/ocs_result.sv
module ocs_result #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         close_i,
  input  logic [W-1:0] final_i,
  output logic [W-1:0] csum_o,
  output logic         done_o,
  output logic         ok_o
);
  localparam logic [W-1:0] ONES = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      csum_o <= '0;
      ok_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= close_i;
      if (close_i) begin
        csum_o <= ~final_i;
        ok_o   <= (final_i == ONES);
      end
    end
  end

  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
    close_i |=> done_o); // R4
  AST_DONE_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    !close_i |=> !done_o); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !close_i |=> ($stable(csum_o) && $stable(ok_o))); // R9
  AST_OK_MATCHES_CSUM: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ok_o == (csum_o == '0))); // R3

endmodule

// File: rtl/ones_csum_unit.sv
module ones_csum_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_word_i,
  input  logic         in_last_i,
  output logic [W-1:0] csum_o,
  output logic         done_o,
  output logic         ok_o
);
  logic [W-1:0] final_sum;
  logic         close;

  ocs_accum #(.W(W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr_i),
    .valid_i (in_valid_i),
    .word_i  (in_word_i),
    .last_i  (in_last_i),
    .final_o (final_sum),
    .close_o (close)
  );

  ocs_result #(.W(W)) u_result (
    .clk     (clk),
    .rst     (rst),
    .close_i (close),
    .final_i (final_sum),
    .csum_o  (csum_o),
    .done_o  (done_o),
    .ok_o    (ok_o)
  );

  AST_CSUM_INVERTS_FINAL: assert property (@(posedge clk) disable iff (rst)
    close |=> (csum_o == ~$past(final_sum))); // R2

endmodule

// File: tb/tb_ones_csum_unit.sv
module tb_ones_csum_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NPKT = 8;
  localparam int WATCHDOG = 20000;

  // word lists, word count, expected checksum, expected ok
  localparam logic [15:0] T_WORD [NPKT][4] = '{
    '{16'h0001, 16'h0002, 16'h0000, 16'h0000},  // R1 no carry
    '{16'hFFFF, 16'h0001, 16'h0000, 16'h0000},  // R10 wrap -> 0001
    '{16'h8000, 16'h8000, 16'hFFFD, 16'h0000},  // R1 carry then add
    '{16'h1234, 16'h5678, 16'h9753, 16'h0000},  // R3 intact packet
    '{16'hFFFF, 16'h0000, 16'h0000, 16'h0000},  // R10 negative zero
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000},  // R10 positive zero
    '{16'hF000, 16'hF000, 16'hF000, 16'hF000},  // R1 repeated carries
    '{16'h1234, 16'h5678, 16'h9752, 16'h0000}   // R3 corrupted
  };
  localparam int          T_CNT  [NPKT] = '{2, 2, 3, 3, 1, 1, 4, 3};
  localparam logic [15:0] T_CSUM [NPKT] = '{16'hFFFC, 16'hFFFE, 16'h0001, 16'h0000,
                                            16'h0000, 16'hFFFF, 16'h3FFC, 16'h0001};
  localparam logic        T_OK   [NPKT] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst, clr, valid, last;
  logic [W-1:0] word;
  logic [W-1:0] csum;
  logic done, ok;

  logic clr8, valid8, last8;
  logic [7:0] word8, csum8;
  logic done8, ok8;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ones_csum_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .clr_i(clr), .in_valid_i(valid),
    .in_word_i(word), .in_last_i(last),
    .csum_o(csum), .done_o(done), .ok_o(ok)
  );

  ones_csum_unit #(.W(8)) dut8 (
    .clk(clk), .rst(rst), .clr_i(clr8), .in_valid_i(valid8),
    .in_word_i(word8), .in_last_i(last8),
    .csum_o(csum8), .done_o(done8), .ok_o(ok8)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w, input logic lst, input logic c);
    @(negedge clk);
    valid = 1'b1; word = w; last = lst; clr = c;
  endtask

  // idle cycle; junk data and last flag that must be ignored
  task automatic idle();
    @(negedge clk);
    valid = 1'b0; word = 16'hA5C3; last = 1'b1; clr = 1'b0;
  endtask

  task automatic put8(input logic [7:0] w, input logic lst);
    @(negedge clk);
    valid8 = 1'b1; word8 = w; last8 = lst;
  endtask

  task automatic idle8();
    @(negedge clk);
    valid8 = 1'b0; word8 = 8'h00; last8 = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; clr = 1'b0; valid = 1'b0; last = 1'b0; word = '0;
    clr8 = 1'b0; valid8 = 1'b0; last8 = 1'b0; word8 = '0;
    repeat (3) @(negedge clk);
    chk("R8", "reset done", {15'd0, done}, 16'd0);
    chk("R8", "reset ok", {15'd0, ok}, 16'd0);
    chk("R8", "reset csum", csum, 16'h0000);
    rst = 1'b0;

    // table walk: packets back to back through automatic restart (R7)
    for (int p = 0; p < NPKT; p++) begin
      for (int i = 0; i < T_CNT[p]; i++)
        put(T_WORD[p][i], (i == T_CNT[p] - 1), 1'b0);
      idle();
      chk("R4", $sformatf("pkt%0d done", p), {15'd0, done}, 16'd1);
      chk("R2", $sformatf("pkt%0d csum", p), csum, T_CSUM[p]);
      chk("R3", $sformatf("pkt%0d ok", p), {15'd0, ok}, {15'd0, T_OK[p]});
      idle();
      chk("R4", $sformatf("pkt%0d done drop", p), {15'd0, done}, 16'd0);
      chk("R9", $sformatf("pkt%0d csum held", p), csum, T_CSUM[p]);
    end

    // R6: invalid cycles carrying junk and last do nothing
    put(16'h0010, 1'b0, 1'b0);
    idle(); idle();
    chk("R6", "no done on invalid last", {15'd0, done}, 16'd0);
    put(16'h0020, 1'b1, 1'b0);
    idle();
    chk("R6", "sum skips invalid words", csum, 16'hFFCF);

    // R5: clear alone, then clear together with a valid word
    put(16'h1111, 1'b0, 1'b0);
    @(negedge clk); valid = 1'b0; clr = 1'b1;
    put(16'h0002, 1'b1, 1'b0);
    idle();
    chk("R5", "clear alone", csum, 16'hFFFD);
    put(16'h1000, 1'b0, 1'b0);
    put(16'h0003, 1'b0, 1'b1);
    put(16'h0004, 1'b1, 1'b0);
    idle();
    chk("R5", "clear with word", csum, 16'hFFF8);

    // R4 and R7: two single-word packets on consecutive cycles
    put(16'h0001, 1'b1, 1'b0);
    put(16'h0002, 1'b1, 1'b0);
    chk("R4", "first b2b done", {15'd0, done}, 16'd1);
    chk("R7", "first b2b csum", csum, 16'hFFFE);
    idle();
    chk("R4", "second b2b done", {15'd0, done}, 16'd1);
    chk("R7", "second b2b csum", csum, 16'hFFFD);

    // R8: reset in the middle of a packet
    put(16'h0100, 1'b0, 1'b0);
    @(negedge clk); valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R8", "mid reset csum", csum, 16'h0000);
    chk("R8", "mid reset ok", {15'd0, ok}, 16'd0);
    rst = 1'b0;
    put(16'h0001, 1'b1, 1'b0);
    idle();
    chk("R8", "accumulator cleared by reset", csum, 16'hFFFE);

    // R2/R3 with W=8: generate then check
    put8(8'hFE, 1'b0);
    put8(8'h05, 1'b1);
    idle8();
    chk("R2", "8-bit checksum", {8'd0, csum8}, 16'h00FB);
    chk("R3", "8-bit generate ok", {15'd0, ok8}, 16'd0);
    put8(8'hFE, 1'b0);
    put8(8'h05, 1'b0);
    put8(8'hFB, 1'b1);
    idle8();
    chk("R3", "8-bit check ok", {15'd0, ok8}, 16'd1);
    chk("R1", "8-bit check csum", {8'd0, csum8}, 16'h0000);
    put8(8'hFF, 1'b0);
    put8(8'h01, 1'b1);
    idle8();
    chk("R10", "8-bit FF+01", {8'd0, csum8}, 16'h00FE);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule